// File: doc/BRIEF.md
# Modem Line Status Register

This block watches four modem handshake inputs: clear-to-send, data-set-ready, ring indicator and carrier detect. It shows them to a processor as one 8-bit status value. The upper nibble gives the present level of each line. The lower nibble holds sticky change flags, so software that polls now and then still sees every transition that happened since its last look. The most recent read clears all four flags. Any flag that is set raises an interrupt request while the interrupt enable input is high.

Each line passes through a two-stage synchroniser. A change is found by comparing the synchronised level with the level one clock earlier. The ring-indicator flag reacts only when the line rises. The other three flags react to an edge in either direction.

The processor reads the register by raising `rd_stb_i` for one clock while it samples `status_o`. During that cycle `status_o` shows the value from before the clear. A change detected in the same cycle as the read is kept, so no event is lost.

Top module: `msr_status_top`

## Requirements
- R1: `status_o[4]`, `[5]`, `[6]` and `[7]` show the synchronised levels of CTS, DSR, RI and DCD. A pin change appears there two clock edges after it is driven.
- R2: `status_o[0]`, `[1]`, `[2]` and `[3]` are the change flags for CTS, DSR, RI and DCD. A 1 means a change was recorded.
- R3: A rising or falling transition on CTS, DSR or DCD sets that line's flag on the third clock edge after the pin changes.
- R4: The RI flag is set only when RI goes from 0 to 1. A 1-to-0 transition of RI leaves the flag at 0.
- R5: A set flag stays set for any number of cycles in which `rd_stb_i` is low.
- R6: A cycle with `rd_stb_i` high clears all four flags at the end of that cycle. The value read in that cycle is the value from before the clear.
- R7: If a line's flag would be set on the same edge that ends a read cycle, the flag stays set after the read.
- R8: `irq_o` is high exactly when `irq_en_i` is high and at least one flag is set. After a clearing read with no new change, `irq_o` is low in the next cycle.
- R9: During and after reset the flags are 0. Lines that are already high when reset is released produce no flag. From the third clock edge after release the block detects changes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cts_i | input | 1 | Clear-to-send line, asynchronous |
| dsr_i | input | 1 | Data-set-ready line, asynchronous |
| ri_i | input | 1 | Ring-indicator line, asynchronous |
| dcd_i | input | 1 | Carrier-detect line, asynchronous |
| rd_stb_i | input | 1 | Register read strobe, one cycle per read |
| irq_en_i | input | 1 | Enable for the modem-status interrupt |
| status_o | output | 8 | Levels in bits 7:4, change flags in bits 3:0 |
| irq_o | output | 1 | Modem-status interrupt request |

## Verification
The change detector is driven with single-line falls and rises, ring-indicator edges in both directions, and two lines changing between reads with a long idle gap in between. Together these separate either-edge detection from rising-only detection and show that flags are sticky. The bench holds all lines high through reset to show that no flag appears when the block starts. It places a transition exactly on the edge that ends a read, which shows whether the clear wins over a new event. It samples the level and flag bits on each edge after a pin change, which pins down the synchroniser and detector latency. The interrupt is observed with the enable both high and low, and again one cycle after a clearing read.

// File: rtl/msr_pkg.sv
package msr_pkg;

  localparam int NUM_LINES = 4;

  // Bit order of the lines inside each nibble of the status value.
  localparam int LN_CTS = 0;
  localparam int LN_DSR = 1;
  localparam int LN_RI  = 2;
  localparam int LN_DCD = 3;

  // Lines whose flag reacts to a rising edge only.
  localparam logic [NUM_LINES-1:0] RISE_ONLY_MASK = 4'b0100;

  // Change event for one line: either edge, or rising edge only.
  function automatic logic line_event(input logic prev_l,
                                      input logic cur_l,
                                      input logic rise_only);
    if (rise_only) return cur_l & ~prev_l;
    return cur_l ^ prev_l;
  endfunction

  // Assemble the register value: levels above, flags below.
  function automatic logic [2*NUM_LINES-1:0] pack_status(input logic [NUM_LINES-1:0] lvl,
                                                         input logic [NUM_LINES-1:0] flg);
    return {lvl, flg};
  endfunction

endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= '0;
    else        pipe[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[s] <= '0;
      else        pipe[s] <= pipe[s-1];
    end
  end

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/msr_delta.sv
module msr_delta
  import msr_pkg::*;
#(
  parameter int                LINES     = NUM_LINES,
  parameter logic [LINES-1:0]  RISE_MASK = RISE_ONLY_MASK,
  parameter int                SETTLE    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lvl,
  input  logic             clr,
  output logic [LINES-1:0] flags,
  output logic [LINES-1:0] evt,
  output logic             armed
);

  localparam int CW = $clog2(SETTLE + 1);
  localparam logic [CW-1:0] SETTLE_C = CW'(SETTLE);

  logic [CW-1:0]    settle_cnt;
  logic [LINES-1:0] prev_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   settle_cnt <= '0;
    else if (settle_cnt != SETTLE_C) settle_cnt <= settle_cnt + 1'b1;
  end

  assign armed = (settle_cnt == SETTLE_C);

  // Previous sample follows the synchronised level from the start, so
  // when detection arms it already equals the lines' present levels.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_lvl <= '0;
    else        prev_lvl <= lvl;
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign evt[i] = armed & line_event(prev_lvl[i], lvl[i], RISE_MASK[i]);

    // A new event wins over a clear on the same edge.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= (flags[i] & ~clr) | evt[i];
    end
  end

endmodule

// File: rtl/msr_irq.sv
module msr_irq #(
  parameter int LINES = 4
) (
  input  logic [LINES-1:0] flags,
  input  logic             en,
  output logic             req
);

  assign req = en & (|flags);

endmodule

// File: rtl/msr_status_top.sv
module msr_status_top
  import msr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cts_i,
  input  logic       dsr_i,
  input  logic       ri_i,
  input  logic       dcd_i,
  input  logic       rd_stb_i,
  input  logic       irq_en_i,
  output logic [7:0] status_o,
  output logic       irq_o
);

  localparam int SETTLE = SYNC_STAGES + 1;

  logic [NUM_LINES-1:0] pin_raw;
  logic [NUM_LINES-1:0] pin_sync;
  logic [NUM_LINES-1:0] line_flag;
  logic [NUM_LINES-1:0] line_evt;
  logic                 armed;

  always_comb begin
    pin_raw         = '0;
    pin_raw[LN_CTS] = cts_i;
    pin_raw[LN_DSR] = dsr_i;
    pin_raw[LN_RI]  = ri_i;
    pin_raw[LN_DCD] = dcd_i;
  end

  msr_sync #(
    .WIDTH  (NUM_LINES),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pin_raw),
    .dout  (pin_sync)
  );

  msr_delta #(
    .LINES     (NUM_LINES),
    .RISE_MASK (RISE_ONLY_MASK),
    .SETTLE    (SETTLE)
  ) u_delta (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (pin_sync),
    .clr   (rd_stb_i),
    .flags (line_flag),
    .evt   (line_evt),
    .armed (armed)
  );

  msr_irq #(
    .LINES (NUM_LINES)
  ) u_irq (
    .flags (line_flag),
    .en    (irq_en_i),
    .req   (irq_o)
  );

  assign status_o = pack_status(pin_sync, line_flag);

endmodule

// File: rtl/msr_status_chk.sv
module msr_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_stb,
  input logic       irq_en,
  input logic       armed,
  input logic [3:0] evt,
  input logic [7:0] status,
  input logic       irq
);

  AST_CTS_EDGE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(armed) && status[4] != $past(status[4])) |=> status[0]) else $error("cts"); // R3

  AST_DCD_EDGE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(armed) && status[7] != $past(status[7])) |=> status[3]) else $error("dcd"); // R3

  AST_RI_FALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(armed) && $fell(status[6]) && !status[2]) |=> !status[2]) else $error("ri fall"); // R4

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> (($past(status[3:0]) & ~status[3:0]) == 4'b0)) else $error("sticky"); // R5

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> ((status[3:0] & ~$past(evt)) == 4'b0)) else $error("clear"); // R6

  AST_IRQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && evt == 4'b0) |=> !irq) else $error("irq drop"); // R8

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq) else $error("irq mask"); // R8

  AST_NO_FLAG_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (status[3:0] == 4'b0)) else $error("settle"); // R9

endmodule

bind msr_status_top msr_status_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .rd_stb (rd_stb_i),
  .irq_en (irq_en_i),
  .armed  (armed),
  .evt    (line_evt),
  .status (status_o),
  .irq    (irq_o)
);

// File: tb/msr_status_top_tb.sv
module msr_status_top_tb;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cts_i = 1'b0, dsr_i = 1'b0, ri_i = 1'b0, dcd_i = 1'b0;
  logic       rd_stb_i = 1'b0;
  logic       irq_en_i = 1'b1;
  logic [7:0] status_o;
  logic       irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Bench model: lvl/flg bit 0 = CTS, 1 = DSR, 2 = RI, 3 = DCD.
  logic [3:0] m_lvl = 4'b0;
  logic [3:0] m_flg = 4'b0;

  logic [7:0] exp_q [$];
  string      tag_q [$];
  event       ev_sample;

  always #(CLK_P/2) clk = ~clk;

  msr_status_top u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .cts_i    (cts_i),
    .dsr_i    (dsr_i),
    .ri_i     (ri_i),
    .dcd_i    (dcd_i),
    .rd_stb_i (rd_stb_i),
    .irq_en_i (irq_en_i),
    .status_o (status_o),
    .irq_o    (irq_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // Apply new pin levels now; optionally update the model's flags.
  task automatic set_pins(input logic [3:0] v, input bit track);
    if (track)
      m_flg = m_flg | ((v ^ m_lvl) & 4'b1011) | (v & ~m_lvl & 4'b0100);
    m_lvl = v;
    cts_i = v[0]; dsr_i = v[1]; ri_i = v[2]; dcd_i = v[3];
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic peek();
    #(CLK_P/4);
  endtask

  // Driver: one read cycle, expected value pushed to the scoreboard.
  task automatic do_read(input string req);
    @(negedge clk);
    rd_stb_i = 1'b1;
    exp_q.push_back({m_lvl, m_flg});
    tag_q.push_back(req);
    m_flg = 4'b0;
    #(CLK_P/4);
    -> ev_sample;
    @(negedge clk);
    rd_stb_i = 1'b0;
  endtask

  // Monitor: compare the value seen during each read cycle.
  initial begin
    forever begin
      @(ev_sample);
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL scoreboard underflow actual=%02h expected=none", status_o);
      end else begin
        chk(tag_q.pop_front(), status_o, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    // R9: all lines high through reset.
    set_pins(4'b1111, 1'b0);
    wait_neg(3);
    peek();
    chk("R9 reset value", status_o, 8'h00);
    chk("R9 reset irq", {7'b0, irq_o}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    wait_neg(8);
    peek();
    chk("R9 no spurious irq", {7'b0, irq_o}, 8'h00);
    do_read("R9 R1 levels after reset");

    // R3 and R1 timing: CTS falls.
    set_pins(4'b1110, 1'b1);
    wait_neg(1); peek();
    chk("R1 level after one edge", {7'b0, status_o[4]}, 8'h01);
    wait_neg(1); peek();
    chk("R1 level after two edges", {7'b0, status_o[4]}, 8'h00);
    chk("R3 flag not yet set", {7'b0, status_o[0]}, 8'h00);
    wait_neg(1); peek();
    chk("R3 flag on third edge", {7'b0, status_o[0]}, 8'h01);
    chk("R8 irq with flag", {7'b0, irq_o}, 8'h01);
    do_read("R2 R3 cts fall");
    peek();
    chk("R8 irq low after read", {7'b0, irq_o}, 8'h00);

    // R4: RI falls, no flag; then rises, flag.
    set_pins(4'b1010, 1'b1);
    wait_neg(5);
    do_read("R4 ri fall ignored");
    set_pins(4'b1110, 1'b1);
    wait_neg(5);
    do_read("R4 ri rise flagged");

    // R5 / R6: DSR then DCD change, long idle, two reads.
    set_pins(4'b1100, 1'b1);
    wait_neg(5);
    set_pins(4'b0100, 1'b1);
    wait_neg(25);
    do_read("R5 sticky dsr dcd");
    do_read("R6 flags cleared by read");

    // R8: masked interrupt.
    irq_en_i = 1'b0;
    set_pins(4'b0101, 1'b1);
    wait_neg(5); peek();
    chk("R8 irq masked", {7'b0, irq_o}, 8'h00);
    irq_en_i = 1'b1;
    wait_neg(1); peek();
    chk("R8 irq unmasked", {7'b0, irq_o}, 8'h01);
    do_read("R8 R3 cts rise");

    // R7: DCD rises so its flag sets on the edge ending a read.
    @(negedge clk);
    set_pins(4'b1101, 1'b0);
    wait_neg(1);
    do_read("R7 read during change");
    m_flg[3] = 1'b1;
    peek();
    chk("R7 irq kept", {7'b0, irq_o}, 8'h01);
    wait_neg(3);
    do_read("R7 kept flag");

    wait_neg(4);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
    end
    done = 1;
    finish_run();
  end

endmodule